// File: doc/BRIEF.md
# ATA PIO Register Cycle Sequencer

This block runs one programmed-I/O register or data cycle at a time on a parallel ATA device bus, using mode 4 timing. A host raises a one-clock request carrying a direction flag, a 5-bit port number and a 16-bit write word. The sequencer drives the device address, the two active-low chip selects, the active-low read or write strobe and the outgoing data bus. It samples the device ready line, and finishes with a one-clock done pulse. For reads, the captured word is available from the done pulse onward.

The phase lengths are given in nanoseconds and converted to clock cycles at elaboration time from the clock frequency. A cycle has four parts in a fixed order. The address settles first. The strobe then stays low for a minimum time, and for longer while the device holds ready low. Last comes a recovery interval with the address still driven. An optional watchdog stops a ready wait that never ends: it releases the strobe, completes the cycle and reports a timeout.

Top module: `pio_cycle_seq`

## Requirements
- R1: A cycle runs in this order: address and chip selects driven with both strobes high for the setup phase, then the strobe low, then the strobe high for the recovery phase with the address still driven, then back to idle.
- R2: Each phase lasts ceil(ns × CLK_MHZ / 1000) clock cycles, with a minimum of 1. At 125 MHz the 25/70/25 ns defaults give 4 setup, 9 minimum strobe and 4 recovery cycles.
- R3: After its minimum time the strobe stays low while `ata_iordy` is sampled low. It rises right after the first clock edge, at or after the minimum, at which `ata_iordy` is sampled high.
- R4: Port bits [2:0] drive `ata_da`, port bit 3 drives `ata_cs0_n` and port bit 4 drives `ata_cs1_n`. Port 0x10 gives cs1_n=1, cs0_n=0 (command block). Port 0x0E gives cs1_n=0, cs0_n=1, da=6 (control block).
- R5: In a cycle only one strobe goes low: `ata_dior_n` when `req_write`=0 and `ata_diow_n` when `req_write`=1. The other strobe stays high throughout.
- R6: In a write cycle, `ata_dout` carries the write word and `ata_doe` is 1 from the first setup cycle through the last recovery cycle. `ata_doe` is 0 in read cycles and in idle.
- R7: In a read cycle, `rsp_rdata` takes the value of `ata_din` sampled at the clock edge that raises DIOR. It holds that value until another read releases its strobe.
- R8: In reset and in idle, both chip selects and both strobes are 1, `ata_da`=0, `ata_dout`=0, `ata_doe`=0 and `rsp_done`=0. After reset, `rsp_rdata` is 0.
- R9: `rsp_done` is 1 for exactly one cycle, the cycle after recovery ends. A request is accepted only while idle, which includes the cycle in which `rsp_done` is 1. A request raised during a cycle is ignored.
- R10: With TIMEOUT_CYC>0, if `ata_iordy` is still low TIMEOUT_CYC cycles after the minimum strobe time, the strobe is released and recovery runs. `rsp_timeout` is then 1 together with `rsp_done`. Otherwise `rsp_timeout` is 0. With TIMEOUT_CYC=0 the wait has no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_port | input | 5 | Port number: {cs1_n, cs0_n, address[2:0]} |
| req_wdata | input | 16 | Write word |
| rsp_rdata | output | 16 | Last captured read word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Ready wait ended by the watchdog (valid with done) |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Outgoing data bus |
| ata_doe | output | 1 | Outgoing data bus enable |
| ata_din | input | 16 | Incoming data bus |
| ata_iordy | input | 1 | Device ready |

## Verification
The cycles cover reads and writes on command-block ports (0x10, 0x11, 0x12, 0x13, 0x17, 0x1F) and on the control port 0x0E. Together they separate the chip-select and address split and the choice of strobe. The device holds ready low for several lengths: none, shorter than the minimum strobe time, somewhat longer than it, and longer than the watchdog limit. These separate the fixed minimum, the ready extension and the timeout path. The incoming data changes every clock, so a read capture taken one edge early or late shows up as a wrong value. Requests raised in the middle of a cycle and a request held across the done pulse check that only idle requests are accepted.

// File: rtl/pio_seq_pkg.sv
// Package: shared phase encoding and the nanosecond-to-cycle conversion
// used by the PIO cycle sequencer. Assumes integer MHz clock rates.
package pio_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_WAIT   = 3'd3,
        PH_RECOV  = 3'd4
    } pio_phase_e;

    // Rounds ns * MHz / 1000 upward, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/pio_port_split.sv
// Splits a host port number into the device address lines and the
// active-low chip select pair. Purely combinational; assumes the port
// is laid out as {cs1_n, cs0_n, address}.
module pio_port_split #(
    parameter int DA_W = 3
) (
    input  logic [DA_W+1:0] port_i,
    output logic [DA_W-1:0] da_o,
    output logic            cs0_n_o,
    output logic            cs1_n_o
);
    // Field extraction: low bits address, next two bits select the block.
    always_comb begin
        da_o    = port_i[DA_W-1:0];
        cs0_n_o = port_i[DA_W];
        cs1_n_o = port_i[DA_W+1];
    end
endmodule

// File: rtl/pio_phase_timer.sv
// Loadable down counter that times one phase. Loading N makes zero_o
// true N cycles later; it then holds at zero. Assumes load values fit
// in CNT_W bits.
module pio_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pio_ready_guard.sv
// Watchdog for the device-ready wait. While active_i is high it counts
// cycles and raises expire_o on the LIMIT-th active cycle. LIMIT = 0
// removes the watchdog entirely.
module pio_ready_guard #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic expire_o
);
    generate
        if (LIMIT == 0) begin : g_off
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ active_i;
            assign expire_o  = 1'b0;
        end else begin : g_on
            localparam int W = $clog2(LIMIT + 1);
            localparam logic [W-1:0] LAST = W'(LIMIT - 1);
            logic [W-1:0] wait_q;

            // Count cycles spent waiting; restart whenever the wait ends.
            always_ff @(posedge clk) begin
                if (!rst_n || !active_i) wait_q <= '0;
                else if (wait_q != LAST) wait_q <= wait_q + 1'b1;
            end

            assign expire_o = active_i && (wait_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pio_cycle_seq.sv
// PIO register cycle sequencer. Runs one read or write cycle per
// request: setup, minimum strobe, ready wait, recovery. All device pins
// are registered. Assumes the host waits for rsp_done before its next
// request; requests during a cycle are dropped.
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int T_SETUP_NS  = 25,
    parameter int T_STROBE_NS = 70,
    parameter int T_RECOV_NS  = 25,
    parameter int TIMEOUT_CYC = 64,
    parameter int DATA_W      = 16,
    parameter int DA_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DA_W+1:0]   req_port,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [DA_W-1:0]   ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [DATA_W-1:0] ata_dout,
    output logic              ata_doe,
    input  logic [DATA_W-1:0] ata_din,
    input  logic              ata_iordy
);
    localparam int SETUP_CYC  = ns_to_cyc(T_SETUP_NS,  CLK_MHZ);
    localparam int STROBE_CYC = ns_to_cyc(T_STROBE_NS, CLK_MHZ);
    localparam int RECOV_CYC  = ns_to_cyc(T_RECOV_NS,  CLK_MHZ);
    localparam int MAX_CYC    = (SETUP_CYC > STROBE_CYC) ?
                                ((SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC) :
                                ((STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD  = CNT_W'(RECOV_CYC - 1);

    pio_phase_e        phase_q;
    logic              write_q;
    logic              err_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              wd_expire;
    logic [DA_W-1:0]   split_da;
    logic              split_cs0_n;
    logic              split_cs1_n;
    logic              accept;
    logic              strobe_go;
    logic              release_go;
    logic              finish_go;

    pio_port_split #(.DA_W(DA_W)) u_split (
        .port_i  (req_port),
        .da_o    (split_da),
        .cs0_n_o (split_cs0_n),
        .cs1_n_o (split_cs1_n)
    );

    pio_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pio_ready_guard #(.LIMIT(TIMEOUT_CYC)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (phase_q == PH_WAIT),
        .expire_o (wd_expire)
    );

    // Phase transition events decoded from the current phase and timers.
    always_comb begin
        accept     = (phase_q == PH_IDLE) && req_valid;
        strobe_go  = (phase_q == PH_SETUP) && tmr_zero;
        release_go = ((phase_q == PH_STROBE) && tmr_zero && ata_iordy) ||
                     ((phase_q == PH_WAIT) && (ata_iordy || wd_expire));
        finish_go  = (phase_q == PH_RECOV) && tmr_zero;
    end

    // Timer reload selection for the phase being entered.
    always_comb begin
        tmr_load = accept || strobe_go || release_go;
        if (accept)         tmr_val = SETUP_LD;
        else if (strobe_go) tmr_val = STROBE_LD;
        else                tmr_val = RECOV_LD;
    end

    // Phase register: walks setup, strobe, wait, recovery, idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   if (accept)    phase_q <= PH_SETUP;
                PH_SETUP:  if (strobe_go) phase_q <= PH_STROBE;
                PH_STROBE: if (tmr_zero)  phase_q <= ata_iordy ? PH_RECOV : PH_WAIT;
                PH_WAIT:   if (release_go) phase_q <= PH_RECOV;
                PH_RECOV:  if (finish_go) phase_q <= PH_IDLE;
                default:                  phase_q <= PH_IDLE;
            endcase
        end
    end

    // Address, chip selects, outgoing data and its enable for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || finish_go) begin
            ata_cs0_n <= 1'b1;
            ata_cs1_n <= 1'b1;
            ata_da    <= '0;
            ata_dout  <= '0;
            ata_doe   <= 1'b0;
            write_q   <= 1'b0;
        end else if (accept) begin
            ata_cs0_n <= split_cs0_n;
            ata_cs1_n <= split_cs1_n;
            ata_da    <= split_da;
            ata_dout  <= req_write ? req_wdata : '0;
            ata_doe   <= req_write;
            write_q   <= req_write;
        end
    end

    // Strobe drive: only the strobe matching the direction ever falls.
    always_ff @(posedge clk) begin
        if (!rst_n || release_go) begin
            ata_dior_n <= 1'b1;
            ata_diow_n <= 1'b1;
        end else if (strobe_go) begin
            ata_dior_n <= write_q;
            ata_diow_n <= !write_q;
        end
    end

    // Read capture on the edge that raises the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rsp_rdata <= '0;
        else if (release_go && !write_q) rsp_rdata <= ata_din;
    end

    // Timeout flag for the cycle in flight, cleared by the next request.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)  err_q <= 1'b0;
        else if (release_go)   err_q <= !ata_iordy;
    end

    // Completion pulse and its timeout qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done    <= 1'b0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_done    <= finish_go;
            rsp_timeout <= finish_go && err_q;
        end
    end

    // ---------------- assertions ----------------
    localparam int RUN_W = $clog2(STROBE_CYC + 2);
    logic [RUN_W-1:0] low_run_q;
    logic             strb_low;
    assign strb_low = !(ata_dior_n && ata_diow_n);

    // Checker state: length of the current strobe-low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !strb_low)            low_run_q <= '0;
        else if (low_run_q != RUN_W'(STROBE_CYC)) low_run_q <= low_run_q + 1'b1;
    end

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n));

    p_strobe_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_dior_n && ata_diow_n) |-> (low_run_q == RUN_W'(STROBE_CYC)));

    p_release_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_dior_n && ata_diow_n) |-> ($past(ata_iordy) || err_q));

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_doe));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ata_doe |-> ata_dior_n);

    p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_low && $past(strb_low)) |-> ($stable(ata_da) && $stable(ata_cs0_n) && $stable(ata_cs1_n)));

    p_timeout_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done);

endmodule

// File: tb/tb_pio_cycle_seq.sv
// Bench: behavioural per-cycle model of the sequencer, compared with the
// design outputs on every falling edge. A small device model drives
// ready stalls and a free-running incoming data word.
module tb_pio_cycle_seq;
    localparam int MHZ = 125;
    localparam int TO  = 20;
    localparam int S   = (25 * MHZ + 999) / 1000;
    localparam int P   = (70 * MHZ + 999) / 1000;
    localparam int R   = (25 * MHZ + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_port = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_timeout;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_doe;
    logic [2:0]  ata_da;
    logic [15:0] ata_dout;
    logic [15:0] ata_din = 16'hC000;
    logic        ata_iordy = 1'b1;

    pio_cycle_seq #(.CLK_MHZ(MHZ), .TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_port(req_port), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .ata_cs0_n(ata_cs0_n),
        .ata_cs1_n(ata_cs1_n), .ata_da(ata_da), .ata_dior_n(ata_dior_n),
        .ata_diow_n(ata_diow_n), .ata_dout(ata_dout), .ata_doe(ata_doe),
        .ata_din(ata_din), .ata_iordy(ata_iordy)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int stall_set = 0;
    int stall_left = 0;
    int low_count = 0;

    // model state
    bit          m_busy = 0, m_wr = 0, m_done = 0, m_to = 0, m_err = 0;
    int          m_t = 0, m_rel = -1;
    logic [4:0]  m_port = '0;
    logic [15:0] m_wdata = '0, m_rdata = '0;

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Reference model step, using the inputs as they stand before the edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_to = 0; m_err = 0; m_rdata = '0;
        end else begin
            m_done = 0; m_to = 0;
            if (m_busy) begin
                m_t++;
                if (m_rel < 0) begin
                    if (m_t >= S + P && (ata_iordy || (TO > 0 && m_t - (S + P) >= TO))) begin
                        m_rel = m_t;
                        if (!m_wr) m_rdata = ata_din;
                        m_err = !ata_iordy;
                    end
                end else if (m_t == m_rel + R) begin
                    m_busy = 0; m_done = 1; m_to = m_err;
                end
            end else if (req_valid) begin
                m_busy = 1; m_t = 0; m_rel = -1; m_err = 0;
                m_wr = req_write; m_port = req_port; m_wdata = req_wdata;
            end
        end
    end

    // Per-cycle comparison, then the device model update.
    always @(negedge clk) begin
        if (rst_n) begin : cmp
            bit on;
            on = m_busy && (m_t >= S) && (m_rel < 0);
            chk("R4", "cs0_n", 16'(ata_cs0_n), 16'(m_busy ? m_port[3] : 1'b1));
            chk("R4", "cs1_n", 16'(ata_cs1_n), 16'(m_busy ? m_port[4] : 1'b1));
            chk("R4", "da",    16'(ata_da),    16'(m_busy ? m_port[2:0] : 3'd0));
            chk("R5", "dior_n", 16'(ata_dior_n), 16'(!(on && !m_wr)));
            chk("R3", "diow_n", 16'(ata_diow_n), 16'(!(on && m_wr)));
            chk("R6", "doe",  16'(ata_doe), 16'(m_busy && m_wr));
            chk("R6", "dout", ata_dout, (m_busy && m_wr) ? m_wdata : 16'h0);
            chk("R7", "rdata", rsp_rdata, m_rdata);
            chk("R9", "done", 16'(rsp_done), 16'(m_done));
            chk("R10", "timeout", 16'(rsp_timeout), 16'(m_to));
        end
        if (!ata_dior_n || !ata_diow_n) begin
            low_count++;
            if (stall_left > 0) begin ata_iordy <= 1'b0; stall_left--; end
            else ata_iordy <= 1'b1;
        end else begin
            ata_iordy  <= 1'b1;
            stall_left = stall_set;
        end
        ata_din <= 16'hC000 | 16'(cyc[11:0]);
    end

    task automatic run_cycle(input bit wr, input logic [4:0] port, input logic [15:0] wd,
                             input int stall, input bit inject);
        stall_set = stall;
        low_count = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_port = port; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_write = !wr; req_port = 5'h07; req_wdata = 16'hDEAD;
            repeat (5) @(negedge clk);
            req_valid = 1'b0;
        end
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state at the pins
        chk("R8", "reset cs0_n", 16'(ata_cs0_n), 16'h1);
        chk("R8", "reset cs1_n", 16'(ata_cs1_n), 16'h1);
        chk("R8", "reset strobes", 16'({ata_dior_n, ata_diow_n}), 16'h3);
        chk("R8", "reset doe/done", 16'({ata_doe, rsp_done}), 16'h0);
        chk("R8", "reset rdata", rsp_rdata, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cycle(1, 5'h10, 16'hA5A5, 0, 0);      // R1 R4 command block write
        chk("R2", "write strobe length", 16'(low_count), 16'(P));
        run_cycle(0, 5'h17, 16'h0, 0, 0);         // R5 read command port
        chk("R2", "read strobe length", 16'(low_count), 16'(P));
        run_cycle(0, 5'h0E, 16'h0, 5, 0);         // R4 control block, short stall
        run_cycle(0, 5'h11, 16'h0, 15, 0);        // R3 stall past minimum
        chk("R3", "extended strobe length", 16'(low_count > P), 16'h1);
        run_cycle(1, 5'h0E, 16'h3C3C, 12, 1);     // R9 requests while busy ignored
        run_cycle(0, 5'h12, 16'h0, 40, 0);        // R10 timeout on read
        chk("R10", "timeout strobe length", 16'(low_count), 16'(P + TO));
        run_cycle(1, 5'h1F, 16'h1234, 50, 0);     // R10 timeout on write
        // R9: request held across done is accepted in the done cycle
        stall_set = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_port = 5'h13;
        @(negedge clk);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "back-to-back accepted", 16'(m_busy), 16'h1);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8", "idle after cycles", 16'({ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}), 16'hF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule